// File: doc/BRIEF.md
# Sub-Block Gated Binary CAM

This block is a binary content-addressable memory holding a parameterised number of entries. Each entry has a tag and a valid bit. The entries are grouped into equal banks, and each bank has its own compare-enable line. A search applies a tag together with a per-bank enable vector. Only enabled banks see the search word and update their match lines. A disabled bank gets a zeroed search word and its match lines are cleared. It reports no match, even when one of its entries holds the searched tag.

An upstream predictor may raise enables loosely, because the exact equality compare inside each enabled bank removes every false candidate. The result is a hit flag, the index of the lowest matching entry, and a flag that says several entries matched. The index addresses a data memory kept outside the block. The block also reports how many banks were enabled for the search, so that the comparison activity can be observed. Tags are written, or entries invalidated, one index per cycle.

Top module: `gated_cam`

## Requirements
- R1: After reset every entry is invalid, and `hit`, `multi_hit`, `rsp_valid`, `hit_idx` and `active_banks` are all zero.
- R2: A cycle with `wr_en` high stores `wr_tag` and `wr_valid` into the entry numbered `wr_idx`. The entry's bank is `wr_idx / BANK_SZ`, and its slot within that bank is `wr_idx % BANK_SZ`.
- R3: `rsp_valid` is high in exactly the cycle after a cycle with `srch_req` high, and the search results are valid in that same cycle.
- R4: A valid entry in an enabled bank matches when every bit of its tag equals `srch_tag`. `hit` then goes to 1 and `hit_idx` gives that entry's index.
- R5: Entries in a bank whose `bank_en` bit was 0 during the search never match, whatever their tag.
- R6: Invalid entries never match.
- R7: When several enabled entries match, `hit_idx` is the lowest matching index and `multi_hit` is 1. With exactly one match `multi_hit` is 0.
- R8: `active_banks` equals the number of 1 bits in `bank_en` during the search.
- R9: Without `srch_req`, `hit`, `hit_idx`, `multi_hit` and `active_banks` keep their last values, even across writes.
- R10: A search issued in the same cycle as a write sees the table contents from before that write.
- R11: When nothing matches, `hit`, `multi_hit` and `hit_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_tag | input | TAG_W | Tag to store |
| wr_valid | input | 1 | Valid bit to store (0 invalidates) |
| srch_req | input | 1 | Search strobe |
| srch_tag | input | TAG_W | Search word |
| bank_en | input | NUM_BANKS | Per-bank compare enables |
| rsp_valid | output | 1 | Search result present this cycle |
| hit | output | 1 | At least one enabled entry matched |
| multi_hit | output | 1 | More than one enabled entry matched |
| hit_idx | output | IDX_W | Lowest matching entry index |
| active_banks | output | CNT_W | Number of banks enabled for the last search |

## Verification
Every search result is due one clock after the request edge, because the match lines are registered at that edge. The bench drives the request on a falling edge and samples all outputs on the falling edge that follows the next rising edge. A write likewise lands at a single edge. The same-cycle write-and-search case is therefore checked in two steps: first the old contents on the response cycle, then the new contents on the following search. The hold checks sample idle cycles in which the search inputs and the table are changed, and compare the outputs with the last response.

// File: rtl/gcam_pkg.sv
package gcam_pkg;
  localparam int MAX_LINES = 64;

  // number of set bits in a vector of up to MAX_LINES lines
  function automatic int count_ones(input logic [MAX_LINES-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < MAX_LINES; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/gcam_bank.sv
module gcam_bank #(
  parameter int BANK_SZ = 4,
  parameter int TAG_W   = 8,
  localparam int SLOT_W = $clog2(BANK_SZ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sel,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic               wr_valid,
  input  logic               srch_req,
  input  logic               bank_en,
  input  logic [TAG_W-1:0]   srch_tag,
  output logic [BANK_SZ-1:0] ml_q
);
  logic [TAG_W-1:0]   tag_q [BANK_SZ];
  logic [BANK_SZ-1:0] vld_q;
  logic [TAG_W-1:0]   drive_word;
  logic [BANK_SZ-1:0] match_now;

  // search-line drive suppressed while the bank is disabled
  assign drive_word = bank_en ? srch_tag : '0;

  for (genvar s = 0; s < BANK_SZ; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[s] <= '0;
        vld_q[s] <= 1'b0;
      end else if (wr_sel && (wr_slot == SLOT_W'(s))) begin
        tag_q[s] <= wr_tag;
        vld_q[s] <= wr_valid;
      end
    end
    assign match_now[s] = bank_en && vld_q[s] && (tag_q[s] == drive_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ml_q <= '0;
    else if (srch_req) ml_q <= match_now;
  end

  // R5: a disabled bank reports no match after the search
  a_r5_disabled_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_req && !bank_en) |=> (ml_q == '0));
  // R9: match lines hold between searches
  a_r9_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_req |=> $stable(ml_q));
  // R6: an entry invalid at search time never raises its line
  for (genvar s = 0; s < BANK_SZ; s++) begin : g_chk
    a_r6_invalid_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_req && !vld_q[s]) |=> !ml_q[s]);
  end
endmodule

// File: rtl/gcam_first_hit.sv
module gcam_first_hit #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] lines,
  output logic             any,
  output logic             several,
  output logic [IDX_W-1:0] first
);
  import gcam_pkg::*;

  always_comb begin
    any   = 1'b0;
    first = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (lines[i]) begin
        any   = 1'b1;
        first = IDX_W'(i);
      end
    end
  end

  assign several = count_ones(MAX_LINES'(lines)) > 1;

  // R7: reported line is set and no lower line is set
  always_comb begin
    if (any) begin
      a_r7_lowest_set: assert (lines[first] && ((lines & ((LINES'(1) << first) - LINES'(1))) == '0));
    end
    if (several) begin
      a_r7_several_implies_any: assert (any);
    end
  end
endmodule

// File: rtl/gated_cam.sv
module gated_cam #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 8,
  parameter int BANK_SZ = 4,
  localparam int NUM_BANKS = ENTRIES / BANK_SZ,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int SLOT_W    = $clog2(BANK_SZ),
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W     = $clog2(NUM_BANKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic                 wr_valid,
  input  logic                 srch_req,
  input  logic [TAG_W-1:0]     srch_tag,
  input  logic [NUM_BANKS-1:0] bank_en,
  output logic                 rsp_valid,
  output logic                 hit,
  output logic                 multi_hit,
  output logic [IDX_W-1:0]     hit_idx,
  output logic [CNT_W-1:0]     active_banks
);
  import gcam_pkg::*;

  logic [ENTRIES-1:0]   ml_all;
  logic [NUM_BANKS-1:0] en_q;
  logic [BANK_W-1:0]    wr_bank;
  logic [BANK_W-1:0]    hit_bank;

  assign wr_bank = BANK_W'(wr_idx >> SLOT_W);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gcam_bank #(.BANK_SZ(BANK_SZ), .TAG_W(TAG_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (wr_en && (wr_bank == BANK_W'(b))),
      .wr_slot  (wr_idx[SLOT_W-1:0]),
      .wr_tag   (wr_tag),
      .wr_valid (wr_valid),
      .srch_req (srch_req),
      .bank_en  (bank_en[b]),
      .srch_tag (srch_tag),
      .ml_q     (ml_all[b*BANK_SZ +: BANK_SZ])
    );
  end

  gcam_first_hit #(.LINES(ENTRIES)) u_first (
    .lines   (ml_all),
    .any     (hit),
    .several (multi_hit),
    .first   (hit_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      en_q         <= '0;
      active_banks <= '0;
    end else begin
      rsp_valid <= srch_req;
      if (srch_req) begin
        en_q         <= bank_en;
        active_banks <= CNT_W'(count_ones(MAX_LINES'(bank_en)));
      end
    end
  end

  assign hit_bank = BANK_W'(hit_idx >> SLOT_W);

  // R3: response exactly one cycle after request
  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    srch_req |=> rsp_valid);
  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_req |=> !rsp_valid);
  // R5: a reported hit lies in a bank enabled for that search
  a_r5_hit_in_enabled_bank: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> en_q[hit_bank]);
  // R8: no more banks reported active than exist
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_banks <= CNT_W'(NUM_BANKS));
  // R9: results hold while idle
  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_req |=> ($stable(hit) && $stable(hit_idx) && $stable(active_banks)));
  // R11: no hit means a zero index
  a_r11_miss_zero_idx: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && !multi_hit));
endmodule

// File: tb/gated_cam_test.sv
module gated_cam_test;
  localparam int PERIOD  = 10;
  localparam int ENTRIES = 16;
  localparam int TAG_W   = 8;
  localparam int BANK_SZ = 4;
  localparam int NB      = ENTRIES / BANK_SZ;
  localparam int IW      = $clog2(ENTRIES);
  localparam int CW      = $clog2(NB + 1);

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_valid = 0, srch_req = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [TAG_W-1:0] wr_tag = '0, srch_tag = '0;
  logic [NB-1:0] bank_en = '0;
  logic rsp_valid, hit, multi_hit;
  logic [IW-1:0] hit_idx;
  logic [CW-1:0] active_banks;

  int checks = 0, errors = 0;
  logic [TAG_W-1:0] m_tag [ENTRIES];
  logic m_vld [ENTRIES];

  always #(PERIOD/2) clk = ~clk;

  gated_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .BANK_SZ(BANK_SZ)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_valid(wr_valid), .srch_req(srch_req), .srch_tag(srch_tag), .bank_en(bank_en),
    .rsp_valid(rsp_valid), .hit(hit), .multi_hit(multi_hit), .hit_idx(hit_idx),
    .active_banks(active_banks));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write(input int idx, input logic [TAG_W-1:0] t, input logic v);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(idx); wr_tag = t; wr_valid = v;
    @(negedge clk);
    wr_en = 0;
    m_tag[idx] = t; m_vld[idx] = v;
  endtask

  // expected outcome computed from the entry model
  task automatic expect_result(input logic [TAG_W-1:0] t, input logic [NB-1:0] en,
                               output int e_hit, output int e_idx, output int e_multi);
    int n;
    n = 0; e_idx = 0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (m_vld[i] && m_tag[i] == t && en[i / BANK_SZ]) begin n++; e_idx = i; end
    e_hit = (n > 0); e_multi = (n > 1);
  endtask

  task automatic check_rsp(input logic [TAG_W-1:0] t, input logic [NB-1:0] en);
    int eh, ei, em, ec;
    expect_result(t, en, eh, ei, em);
    ec = $countones(en);
    chk(rsp_valid == 1, "R3 rsp_valid", int'(rsp_valid), 1);
    chk(int'(hit) == eh, eh ? "R4 hit" : "R5/R6/R11 miss", int'(hit), eh);
    chk(int'(hit_idx) == ei, "R4/R7/R11 hit_idx", int'(hit_idx), ei);
    chk(int'(multi_hit) == em, "R7 multi_hit", int'(multi_hit), em);
    chk(int'(active_banks) == ec, "R8 active_banks", int'(active_banks), ec);
  endtask

  task automatic search(input logic [TAG_W-1:0] t, input logic [NB-1:0] en);
    @(negedge clk);
    srch_req = 1; srch_tag = t; bank_en = en;
    @(negedge clk);
    srch_req = 0;
    check_rsp(t, en);
  endtask

  function automatic logic [TAG_W-1:0] tag_of(input int i);
    return TAG_W'(i * 37 + 5);
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h0, i0, a0, mh0;
    for (int i = 0; i < ENTRIES; i++) begin m_tag[i] = '0; m_vld[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 0 && hit == 0 && multi_hit == 0, "R1 flags", int'(hit), 0);
    chk(hit_idx == 0 && active_banks == 0, "R1 idx/count", int'(hit_idx), 0);
    rst_n = 1;
    // R1/R6: empty table, tag 0 with all banks enabled must miss
    search('0, '1);
    // R2: fill every entry with a distinct tag
    for (int i = 0; i < ENTRIES; i++) write(i, tag_of(i), 1'b1);
    // R4/R5/R8: sweep all enable patterns over every stored tag
    for (int e = 0; e < (1 << NB); e++)
      for (int i = 0; i < ENTRIES; i++) search(tag_of(i), NB'(e));
    // R11: absent tag
    search(8'hFF, '1);
    // R7: duplicates in different banks, lowest reported
    write(13, tag_of(6), 1'b1);
    write(9, tag_of(6), 1'b1);
    for (int e = 0; e < (1 << NB); e++) search(tag_of(6), NB'(e));
    // R6: invalidate entry 6, duplicates remain
    write(6, tag_of(6), 1'b0);
    search(tag_of(6), '1);
    write(9, tag_of(9), 1'b1);
    write(13, tag_of(13), 1'b1);
    search(tag_of(6), '1);
    // R10: write and search in the same cycle sees old contents
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(2); wr_tag = 8'hFF; wr_valid = 1;
    srch_req = 1; srch_tag = 8'hFF; bank_en = '1;
    @(negedge clk);
    wr_en = 0; srch_req = 0;
    check_rsp(8'hFF, '1);
    m_tag[2] = 8'hFF; m_vld[2] = 1;
    search(8'hFF, '1);
    // R9: hold across idle cycles with changing inputs and a write
    h0 = hit; i0 = hit_idx; a0 = active_banks; mh0 = multi_hit;
    @(negedge clk);
    srch_tag = tag_of(4); bank_en = 4'b0001;
    wr_en = 1; wr_idx = IW'(2); wr_tag = tag_of(2); wr_valid = 1;
    @(negedge clk);
    wr_en = 0; m_tag[2] = tag_of(2);
    @(negedge clk);
    chk(rsp_valid == 0, "R3/R9 idle rsp_valid", int'(rsp_valid), 0);
    chk(int'(hit) == h0 && int'(multi_hit) == mh0, "R9 hit hold", int'(hit), h0);
    chk(int'(hit_idx) == i0, "R9 idx hold", int'(hit_idx), i0);
    chk(int'(active_banks) == a0, "R9 count hold", int'(active_banks), a0);
    search(tag_of(2), '1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule